// File: doc/BRIEF.md
# Reset and Power-Fail Supervisor

This block collects every reason a processor board may need to restart and steers them all through one ordered path. The sources are a manual reset switch, an internal watchdog, a power supply "good" signal, a software strobe and a request from an external device. Each of them first raises an early-warning non-maskable interrupt. A fixed holdoff then runs, equal to 1 ms at the system clock. Only after that are the board reset and the RAM chip-select protection applied. Firmware therefore gets a guaranteed window to update counters in battery-backed RAM before anything is lost.

A separate fast input from a supply level detector is the only exception. It bypasses the warning and applies reset and protection at once. A status port records the first cause seen. It needs no setup to read, it survives the reset it caused, and it flags any further cause that arrives before software clears it. The watchdog runs from power-on with no configuration and can be switched off by a jumper input. While protection is active, the RAM chip-select output is driven actively high.

All interfaces are plain control and status levels or strobes. There is no streamed data, so no valid/ready handshake exists and there is no back-pressure. Asynchronous inputs pass through two-flop synchronisers. `prog_req_i`, `wdg_kick_i` and `stat_clr_i` are taken as synchronous to `clk`.

Top module: `rstsup_top`

## Requirements
- R1: While `por_n` is low, `rst_o` and `ram_prot_o` are 1, `nmi_o` is 0, and the status is cleared (valid 0, cause 0, overflow 0). After release with the supply good, `rst_o` stays high for RST_CYC-1 sampled cycles, and then protection drops one cycle later.
- R2: A rising edge on the manual, external or software request, a watchdog expiry, or a falling edge of `pwr_good_i` raises `nmi_o` for exactly HOLD_CYC = CLK_HZ/1000 cycles. Then `rst_o` rises while `nmi_o` falls. `nmi_o` and `rst_o` are never high together.
- R3: `ram_prot_o` rises on the same edge as `rst_o`. `rst_o` lasts RST_CYC cycles, and stays asserted as long as the supply is not good. `ram_prot_o` falls one cycle after `rst_o` falls, and only with the supply good.
- R4: While `ram_prot_o` is 1, `ram_cs_n_o` is driven to 1. Otherwise it follows `ram_cs_n_i`.
- R5: A high `vcc_drop_i` asserts `rst_o` and `ram_prot_o` within three clocks, with no NMI, and cuts short any running holdoff. Reset is held while the input stays high, and RST_CYC cycles after it returns low.
- R6: With the watchdog enabled and the board idle, no kick for WDG_CYC cycles starts the sequence of R2 with cause watchdog. Kicks at shorter intervals prevent it.
- R7: With `wdg_off_i` high the watchdog never fires.
- R8: Cause codes on `stat_cause_o` are: 1 manual, 2 power fail, 3 watchdog, 4 software, 5 external, 6 supply drop. The first cause is latched with `stat_valid_o`, and it is held through the reset it triggers.
- R9: Any further cause arriving while the status is valid sets `stat_ovf_o`, and the latched code stays unchanged.
- R10: A `stat_clr_i` strobe clears valid, cause and overflow.
- R11: Each event runs the sequence once. A held switch does not repeat it, and a cause arriving during a running sequence neither restarts nor lengthens the holdoff.
- R12: Causes detected in the same cycle are ranked supply drop, power fail, watchdog, manual, software, external. The winner is latched and overflow is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| man_req_i | input | 1 | Manual reset switch, high when pressed |
| ext_req_i | input | 1 | External device reset request, high active |
| prog_req_i | input | 1 | Software reset strobe, synchronous |
| pwr_good_i | input | 1 | Power supply good, low warns of failure |
| vcc_drop_i | input | 1 | Level detector: supply collapsing, high active |
| wdg_kick_i | input | 1 | Watchdog restart strobe, synchronous |
| wdg_off_i | input | 1 | Watchdog disable jumper, high disables |
| ram_cs_n_i | input | 1 | RAM chip select from the address decoder, active low |
| stat_clr_i | input | 1 | Status clear strobe from the CPU |
| nmi_o | output | 1 | Impending-reset non-maskable interrupt |
| rst_o | output | 1 | Board reset, high active |
| ram_prot_o | output | 1 | RAM protection active |
| ram_cs_n_o | output | 1 | Gated RAM chip select, forced high under protection |
| stat_valid_o | output | 1 | A cause is latched |
| stat_cause_o | output | 3 | Latched cause code |
| stat_ovf_o | output | 1 | More than one cause since the last clear |

## Verification
The bench measures the NMI width against HOLD_CYC and the reset width against RST_CYC. An off-by-one counter, or a design that skips the warning, shows up as a wrong count or as reset arriving with the NMI still high.

It injects a second cause part-way through the holdoff. A design that restarted the sequence would report a long NMI, and one that overwrote the status would report the wrong code. It also holds the manual switch down for a long time, where a level-triggered design would loop through resets.

Further cases cover:
- a supply drop mid-holdoff, where a design that ignores it would still warn;
- a supply that stays bad during reset, where a design would release reset too early;
- simultaneous causes, where a wrong priority order reports the wrong code;
- watchdog kicking and the disable jumper.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_MANUAL  = 3'd1,
    CAUSE_PWRFAIL = 3'd2,
    CAUSE_WDOG    = 3'd3,
    CAUSE_PROG    = 3'd4,
    CAUSE_EXT     = 3'd5,
    CAUSE_VDROP   = 3'd6
  } cause_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WARN,
    SEQ_RST,
    SEQ_PROT
  } seq_e;

  // one-cycle event pulses, one per source
  typedef struct packed {
    logic vdrop;
    logic pwr;
    logic wdg;
    logic man;
    logic prog;
    logic ext;
  } evt_t;

  // fixed ranking when several events share a cycle
  function automatic cause_e pick_cause(evt_t e);
    if (e.vdrop)      return CAUSE_VDROP;
    else if (e.pwr)   return CAUSE_PWRFAIL;
    else if (e.wdg)   return CAUSE_WDOG;
    else if (e.man)   return CAUSE_MANUAL;
    else if (e.prog)  return CAUSE_PROG;
    else if (e.ext)   return CAUSE_EXT;
    return CAUSE_NONE;
  endfunction

endpackage

// File: rtl/rstsup_sync.sv
module rstsup_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/rstsup_wdg.sv
module rstsup_wdg #(
  parameter int WDG_CYC = 1000
) (
  input  logic clk,
  input  logic por_n,
  input  logic kick,
  input  logic disable_s,
  input  logic idle,
  output logic expire
);
  localparam int WW = $clog2(WDG_CYC + 1);
  localparam logic [WW-1:0] LOAD = WW'(WDG_CYC - 1);

  logic [WW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                          cnt <= LOAD;
    else if (kick || disable_s || !idle) cnt <= LOAD;
    else if (cnt != '0)                  cnt <= cnt - 1'b1;
  end

  assign expire = idle && !disable_s && !kick && (cnt == '0);
endmodule

// File: rtl/rstsup_cause.sv
module rstsup_cause
  import rstsup_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  evt_t   evt,
  input  logic   clr,
  output cause_e cause,
  output logic   valid,
  output logic   ovf
);
  logic   any_evt, multi_evt;
  cause_e cause_n;
  logic   valid_n, ovf_n;

  assign any_evt   = |evt;
  assign multi_evt = $countones(evt) > 1;

  always_comb begin
    cause_n = cause;
    valid_n = valid;
    ovf_n   = ovf;
    if (clr) begin
      cause_n = CAUSE_NONE;
      valid_n = 1'b0;
      ovf_n   = 1'b0;
    end
    if (any_evt) begin
      if (valid_n) begin
        ovf_n = 1'b1;
      end else begin
        cause_n = pick_cause(evt);
        valid_n = 1'b1;
        ovf_n   = multi_evt;
      end
    end
  end

  // cleared only by power-on or CPU strobe, never by the board reset
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause <= CAUSE_NONE;
      valid <= 1'b0;
      ovf   <= 1'b0;
    end else begin
      cause <= cause_n;
      valid <= valid_n;
      ovf   <= ovf_n;
    end
  end
endmodule

// File: rtl/rstsup_seq.sv
module rstsup_seq
  import rstsup_pkg::*;
#(
  parameter int HOLD_CYC = 1000,
  parameter int RST_CYC  = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic start,
  input  logic vdrop_lvl,
  input  logic pwr_good,
  output logic idle,
  output logic nmi,
  output logic rst,
  output logic prot
);
  localparam int MAXC = (HOLD_CYC > RST_CYC) ? HOLD_CYC : RST_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HOLD_LD = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] RST_LD  = CW'(RST_CYC - 1);

  seq_e          st, st_n;
  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    unique case (st)
      SEQ_IDLE: if (start) begin
        st_n  = SEQ_WARN;
        cnt_n = HOLD_LD;
      end
      SEQ_WARN: if (cnt == '0) begin
        st_n  = SEQ_RST;
        cnt_n = RST_LD;
      end else begin
        cnt_n = cnt - 1'b1;
      end
      SEQ_RST: if (cnt != '0) begin
        cnt_n = cnt - 1'b1;
      end else if (pwr_good) begin
        st_n = SEQ_PROT;
      end
      SEQ_PROT: if (pwr_good) st_n = SEQ_IDLE;
      default: st_n = SEQ_RST;
    endcase
    // collapsing supply overrides every state
    if (vdrop_lvl) begin
      st_n  = SEQ_RST;
      cnt_n = RST_LD;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st   <= SEQ_RST;
      cnt  <= RST_LD;
      nmi  <= 1'b0;
      rst  <= 1'b1;
      prot <= 1'b1;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      nmi  <= (st_n == SEQ_WARN);
      rst  <= (st_n == SEQ_RST);
      prot <= (st_n == SEQ_RST) || (st_n == SEQ_PROT);
    end
  end

  assign idle = (st == SEQ_IDLE);
endmodule

// File: rtl/rstsup_top.sv
module rstsup_top
  import rstsup_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int RST_CYC = 16,
  parameter int WDG_CYC = 100_000
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       man_req_i,
  input  logic       ext_req_i,
  input  logic       prog_req_i,
  input  logic       pwr_good_i,
  input  logic       vcc_drop_i,
  input  logic       wdg_kick_i,
  input  logic       wdg_off_i,
  input  logic       ram_cs_n_i,
  input  logic       stat_clr_i,
  output logic       nmi_o,
  output logic       rst_o,
  output logic       ram_prot_o,
  output logic       ram_cs_n_o,
  output logic       stat_valid_o,
  output logic [2:0] stat_cause_o,
  output logic       stat_ovf_o
);
  localparam int HOLD_CYC = CLK_HZ / 1000;
  localparam int NSYNC    = 5;

  logic [NSYNC-1:0] sync_q;
  logic man_s, ext_s, pwr_s, vcc_s, woff_s;
  logic man_p, ext_p, pwr_p, vcc_p, prog_p;
  logic idle, wdg_exp;
  evt_t evt;
  cause_e cause;

  rstsup_sync #(.W(NSYNC), .STAGES(2)) u_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     ({wdg_off_i, vcc_drop_i, pwr_good_i, ext_req_i, man_req_i}),
    .q     (sync_q)
  );
  assign {woff_s, vcc_s, pwr_s, ext_s, man_s} = sync_q;

  // previous-cycle copies for edge qualification
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      man_p  <= 1'b0;
      ext_p  <= 1'b0;
      pwr_p  <= 1'b0;
      vcc_p  <= 1'b0;
      prog_p <= 1'b0;
    end else begin
      man_p  <= man_s;
      ext_p  <= ext_s;
      pwr_p  <= pwr_s;
      vcc_p  <= vcc_s;
      prog_p <= prog_req_i;
    end
  end

  rstsup_wdg #(.WDG_CYC(WDG_CYC)) u_wdg (
    .clk       (clk),
    .por_n     (por_n),
    .kick      (wdg_kick_i),
    .disable_s (woff_s),
    .idle      (idle),
    .expire    (wdg_exp)
  );

  assign evt.vdrop = vcc_s & ~vcc_p;
  assign evt.pwr   = pwr_p & ~pwr_s;
  assign evt.wdg   = wdg_exp;
  assign evt.man   = man_s & ~man_p;
  assign evt.prog  = prog_req_i & ~prog_p;
  assign evt.ext   = ext_s & ~ext_p;

  rstsup_seq #(.HOLD_CYC(HOLD_CYC), .RST_CYC(RST_CYC)) u_seq (
    .clk       (clk),
    .por_n     (por_n),
    .start     (evt.pwr | evt.wdg | evt.man | evt.prog | evt.ext),
    .vdrop_lvl (vcc_s),
    .pwr_good  (pwr_s),
    .idle      (idle),
    .nmi       (nmi_o),
    .rst       (rst_o),
    .prot      (ram_prot_o)
  );

  rstsup_cause u_cause (
    .clk   (clk),
    .por_n (por_n),
    .evt   (evt),
    .clr   (stat_clr_i),
    .cause (cause),
    .valid (stat_valid_o),
    .ovf   (stat_ovf_o)
  );

  assign stat_cause_o = cause;
  assign ram_cs_n_o   = ram_prot_o ? 1'b1 : ram_cs_n_i;
endmodule

// File: rtl/rstsup_chk.sv
module rstsup_chk #(
  parameter int HOLD_CYC = 1000
) (
  input logic       clk,
  input logic       por_n,
  input logic       nmi,
  input logic       rst,
  input logic       prot,
  input logic       cs_n_o,
  input logic       vcc_s,
  input logic       pwr_s,
  input logic       stat_valid,
  input logic       stat_ovf,
  input logic [2:0] stat_cause,
  input logic       stat_clr
);
  localparam int RW = $clog2(HOLD_CYC + 2);
  logic [RW-1:0] nmi_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   nmi_run <= '0;
    else if (nmi) nmi_run <= nmi_run + 1'b1;
    else          nmi_run <= '0;
  end

  AST_NMI_RST_EXCL: assert property (@(posedge clk) disable iff (!por_n)
    !(nmi && rst)); // R2
  AST_RST_WARNED: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst) |-> ($past(nmi) || $past(vcc_s))); // R5
  AST_NMI_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(nmi) && !$past(vcc_s)) |-> (nmi_run == RW'(HOLD_CYC))); // R2
  AST_PROT_WITH_RST: assert property (@(posedge clk) disable iff (!por_n)
    rst |-> prot); // R3
  AST_PROT_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    $fell(prot) |-> (!rst && $past(pwr_s))); // R3
  AST_CS_DRIVEN: assert property (@(posedge clk) disable iff (!por_n)
    rst |-> cs_n_o); // R4
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!por_n)
    (stat_valid && $past(stat_valid) && !$past(stat_clr)) |-> $stable(stat_cause)); // R8
  AST_OVF_VALID: assert property (@(posedge clk) disable iff (!por_n)
    stat_ovf |-> stat_valid); // R9
endmodule

bind rstsup_top rstsup_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .nmi        (nmi_o),
  .rst        (rst_o),
  .prot       (ram_prot_o),
  .cs_n_o     (ram_cs_n_o),
  .vcc_s      (vcc_s),
  .pwr_s      (pwr_s),
  .stat_valid (stat_valid_o),
  .stat_ovf   (stat_ovf_o),
  .stat_cause (stat_cause_o),
  .stat_clr   (stat_clr_i)
);

// File: tb/test_rstsup_top.sv
module test_rstsup_top;
  localparam int CLK_HZ  = 40_000;
  localparam int HOLD    = CLK_HZ / 1000;
  localparam int RST_CYC = 12;
  localparam int WDG_CYC = 90;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic man = 0, ext = 0, prog = 0, pwr = 1, vdrop = 0, kick = 0, woff = 1, csi = 1, clr = 0;
  logic nmi, rst, prot, cso, sval, sovf;
  logic [2:0] scause;
  int ncmp = 0, nerr = 0;

  always #2.5 clk = ~clk;

  rstsup_top #(.CLK_HZ(CLK_HZ), .RST_CYC(RST_CYC), .WDG_CYC(WDG_CYC)) i_rstsup_top (
    .clk(clk), .por_n(por_n), .man_req_i(man), .ext_req_i(ext), .prog_req_i(prog),
    .pwr_good_i(pwr), .vcc_drop_i(vdrop), .wdg_kick_i(kick), .wdg_off_i(woff),
    .ram_cs_n_i(csi), .stat_clr_i(clr), .nmi_o(nmi), .rst_o(rst), .ram_prot_o(prot),
    .ram_cs_n_o(cso), .stat_valid_o(sval), .stat_cause_o(scause), .stat_ovf_o(sovf)
  );

  task automatic chk(string req, int act, int exp);
    ncmp++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_cause(int src);
    case (src)
      0: return 1; 1: return 2; 2: return 3; 3: return 4; default: return 5;
    endcase
  endfunction

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_stat();
    clr = 1; cyc(1); clr = 0; cyc(1);
  endtask

  task automatic wait_nmi(string req, int lim);
    int w = 0;
    while (!nmi && w < lim) begin cyc(1); w++; end
    chk({req, " nmi raised"}, nmi, 1);
  endtask

  // nmi must be high now; measure the rest of the sequence
  task automatic finish_seq(string req, int already);
    int n = already;
    int m = 0;
    while (nmi && n < 1000) begin n++; cyc(1); end
    chk({req, " R2 nmi width"}, n, HOLD);
    chk("R3 reset with protect", {rst, prot}, 3);
    chk("R4 cs forced high", cso, 1);
    while (rst && m < 1000) begin m++; cyc(1); end
    chk("R3 reset width", m, RST_CYC);
    chk("R3 protect after reset", prot, 1);
    cyc(1);
    chk("R3 protect released", prot, 0);
    chk("R4 cs follows", cso, csi);
  endtask

  task automatic no_nmi(string req, int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin cyc(1); if (nmi || rst) seen = 1; end
    chk(req, seen, 0);
  endtask

  initial begin : wd
    cyc(150000);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end

  initial begin : main
    int m;
    int src;
    int seen;
    csi = 0;
    cyc(4);
    // R1 power-on state
    chk("R1 por outputs", {nmi, rst, prot, cso}, 4'b0111);
    chk("R1 por status", {sval, scause, sovf}, 0);
    por_n = 1;
    m = 0;
    cyc(1);
    while (rst && m < 100) begin m++; cyc(1); end
    chk("R1 reset after por", m, RST_CYC - 1);
    chk("R1 protect tail", prot, 1);
    cyc(1);
    chk("R1 released", {nmi, rst, prot}, 0);
    // R4 pass-through when idle
    csi = 0; cyc(1); chk("R4 idle cs low", cso, 0);
    csi = 1; cyc(1); chk("R4 idle cs high", cso, 1);

    // random sources, R2 R6 R8
    for (int it = 0; it < 14; it++) begin
      src = $urandom % 5;
      csi = 1'($urandom % 2);
      clear_stat();
      case (src)
        0: man = 1;
        1: pwr = 0;
        2: woff = 0;
        3: begin prog = 1; cyc(1); prog = 0; end
        default: ext = 1;
      endcase
      wait_nmi("R2", (src == 2) ? WDG_CYC + 20 : 10);
      pwr = 1; woff = 1;
      finish_seq("R2", 0);
      chk("R8 cause latched", scause, exp_cause(src));
      chk("R8 valid no ovf", {sval, sovf}, 2'b10);
      man = 0; ext = 0;
      cyc(4 + ($urandom % 8));
    end

    // R11 held switch
    clear_stat();
    man = 1;
    wait_nmi("R11", 10);
    finish_seq("R11", 0);
    no_nmi("R11 held switch no repeat", 150);
    man = 0; cyc(4);

    // R11 / R9 second cause during holdoff
    clear_stat();
    prog = 1; cyc(1); prog = 0;
    wait_nmi("R11", 5);
    cyc(10);
    ext = 1;
    finish_seq("R11 no restart", 10);
    chk("R9 cause kept", scause, 4);
    chk("R9 overflow", sovf, 1);
    ext = 0; cyc(3);
    clr = 1; cyc(1); clr = 0;
    chk("R10 cleared", {sval, scause, sovf}, 0);

    // R3 supply bad during reset
    prog = 1; cyc(1); prog = 0;
    wait_nmi("R3", 5);
    while (!rst) cyc(1);
    pwr = 0;
    cyc(3 * RST_CYC);
    chk("R3 reset held while supply bad", {rst, prot}, 3);
    chk("R9 power fail adds overflow", {scause, sovf}, {3'd4, 1'b1});
    pwr = 1;
    m = 0;
    while (rst && m < 20) begin m++; cyc(1); end
    chk("R3 released after supply good", rst, 0);
    chk("R3 protect trails", prot, 1);
    cyc(1);
    chk("R3 protect dropped", prot, 0);
    cyc(3);

    // R5 supply drop while idle
    clear_stat();
    vdrop = 1;
    seen = 0;
    for (int i = 0; i < 4; i++) begin cyc(1); if (nmi) seen = 1; end
    chk("R5 no nmi", seen, 0);
    chk("R5 immediate reset", {rst, prot}, 3);
    cyc(50);
    chk("R5 held", rst, 1);
    chk("R8 supply drop code", scause, 6);
    vdrop = 0;
    m = 0;
    while (rst && m < 40) begin m++; cyc(1); end
    chk("R5 release bounded", (m >= RST_CYC && m <= RST_CYC + 4) ? 1 : 0, 1);
    cyc(2);
    chk("R5 protect off", prot, 0);

    // R5 supply drop during holdoff
    clear_stat();
    prog = 1; cyc(1); prog = 0;
    wait_nmi("R5", 5);
    cyc(5);
    vdrop = 1;
    cyc(4);
    chk("R5 cut short", {nmi, rst}, 2'b01);
    vdrop = 0;
    m = 0;
    while (rst && m < 40) begin m++; cyc(1); end
    cyc(2);
    chk("R5 overflow, prog kept", {scause, sovf}, {3'd4, 1'b1});

    // R12 simultaneous causes
    clear_stat();
    man = 1; ext = 1;
    wait_nmi("R12", 10);
    finish_seq("R12", 0);
    chk("R12 manual over external", {scause, sovf}, {3'd1, 1'b1});
    man = 0; ext = 0; cyc(4);
    clear_stat();
    man = 1; pwr = 0;
    wait_nmi("R12", 10);
    pwr = 1;
    finish_seq("R12", 0);
    chk("R12 power over manual", {scause, sovf}, {3'd2, 1'b1});
    man = 0; cyc(4);

    // R6 kicks hold off the watchdog
    clear_stat();
    woff = 0;
    seen = 0;
    for (int k = 0; k < 15; k++) begin
      kick = 1; cyc(1); kick = 0;
      for (int i = 0; i < WDG_CYC / 2; i++) begin cyc(1); if (nmi) seen = 1; end
    end
    chk("R6 kicked no expiry", seen, 0);
    // R7 jumper disables
    woff = 1;
    no_nmi("R7 disabled no expiry", 4 * WDG_CYC);
    chk("R7 status untouched", sval, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nerr);
    $finish;
  end
endmodule